// File: doc/BRIEF.md
# MDIO Management Frame Launcher

This block sends management frames to an attached PHY over the two-wire MDC/MDIO link. Software loads a 32-bit frame word through a write strobe. The word holds the start code, the opcode, the PHY address, the register address, the turnaround and 16 data bits. A second write strobe loads the clock divider, which sets the MDC rate. A divider of zero stops the management clock. While it is zero, no frame goes out.

A frame word written while the divider is zero is kept. It is sent as soon as the divider becomes non-zero, so the two values can be loaded in either order. A word written while a frame is on the wire is also kept and is sent once that frame ends. Each frame starts with a preamble of ones, followed by the frame word, most significant bit first. For a read opcode the block releases MDIO, shifts in the PHY's 16 data bits and stores them in the low half of the frame word. Every frame ends with a one-cycle done pulse and a sticky event flag, which software clears with a write of one.

Top module: `mdioMgmtLauncher`

## Requirements
- R1: While the divider is zero, MDC stays low, MDIO is not driven and no frame starts, even if a frame word has been written.
- R2: With a non-zero divider, a frame word write starts a frame. MDIO carries 32 ones and then frame word bits 31 down to 0. Each bit changes while MDC is low and is stable at the rising edge of MDC.
- R3: Each MDC high phase and each MDC low phase lasts exactly as many system clocks as the divider value.
- R4: A read frame has frame bits 29:28 equal to 2'b10. In a read frame the MDIO output enable falls from frame bit 16 (the second turnaround bit) to the end of the frame. The 16 bits sampled at the following rising MDC edges are stored, first bit as bit 15, in bits 15:0 of the frame word. Bits 31:16 keep the written value.
- R5: In any other opcode, the output enable stays high for all 64 bits, and a read of the frame word returns the written value unchanged.
- R6: A frame word written while the divider is zero is sent, unchanged, right after the divider is written with a non-zero value.
- R7: The clock edge that ends the last bit's high phase raises the done pulse for exactly one cycle and sets the event flag.
- R8: Asserting the clear input clears the event flag on the next edge. If a frame ends on the same edge, the flag stays set.
- R9: A frame word written during a frame is held and sent after the current frame ends. Read data from the current frame is not stored over the newer word.
- R10: After reset, MDC, the output enable, the done pulse, the event flag, busy and the divider are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameWrEn | input | 1 | Write strobe for the frame word |
| frameWrData | input | 32 | Frame word to write |
| frameRdData | output | 32 | Current frame word, including captured read data |
| divWrEn | input | 1 | Write strobe for the divider |
| divWrData | input | DIV_W | Divider value to write |
| divValue | output | DIV_W | Current divider value |
| eventClr | input | 1 | Write-one-to-clear strobe for the event flag |
| mdioIn | input | 1 | MDIO pad input |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO pad output value |
| mdioOe | output | 1 | MDIO pad output enable |
| busy | output | 1 | Frame in progress |
| donePulse | output | 1 | One-cycle pulse at frame end |
| eventFlag | output | 1 | Sticky frame-complete event |

## Verification
Two functions can fall on the same clock edge: the end of a frame, which sets the event flag, and a software clear of that flag. The bench counts system clocks from the frame word write to compute the exact edge on which the frame ends, and drives the clear for that single edge. It passes if the done pulse and the event flag are both high afterwards, and if a later clear on its own drops the flag. A second pairing, a frame word write that arrives during a read frame, is judged by checking that the word read back is the new one and that the new word is sent next.

// File: rtl/mdioMgmtPkg.sv
package mdioMgmtPkg;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic load;      // copy frame word into shifter
    logic shift;     // advance to next frame bit
    logic sample;    // shift in one MDIO read bit
    logic capture;   // store read data into frame word
    logic preamble;  // drive the preamble one
  } pathStrb_t;
endpackage

// File: rtl/mdioMgmtPath.sv
module mdioMgmtPath
  import mdioMgmtPkg::*;
(
  input  logic                  clk,
  input  logic                  frameWrEn,
  input  logic [FRAME_BITS-1:0] frameWrData,
  input  pathStrb_t             strb,
  input  logic                  mdioIn,
  output logic [FRAME_BITS-1:0] frameRdData,
  output logic                  mdioOut,
  output logic                  isRead
);
  logic [FRAME_BITS-1:0] frameReg;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0]  rxReg;
  logic                  readQ;

  // The frame word has no defined reset value, so it has no reset.
  always_ff @(posedge clk) begin
    if (frameWrEn) begin
      frameReg <= frameWrData;
    end else if (strb.capture) begin
      frameReg[DATA_BITS-1:0] <= rxReg;
    end
    if (strb.load) begin
      shiftReg <= frameReg;
      readQ    <= (frameReg[29:28] == OP_READ);
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
    end
    if (strb.sample) begin
      rxReg <= {rxReg[DATA_BITS-2:0], mdioIn};
    end
  end

  assign frameRdData = frameReg;
  assign mdioOut     = strb.preamble ? 1'b1 : shiftReg[FRAME_BITS-1];
  assign isRead      = readQ;
endmodule

// File: rtl/mdioMgmtCtrl.sv
module mdioMgmtCtrl
  import mdioMgmtPkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameWrEn,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             eventClr,
  input  logic             isRead,
  output pathStrb_t        strb,
  output logic [DIV_W-1:0] divValue,
  output logic             mdc,
  output logic             mdioOe,
  output logic             busy,
  output logic             donePulse,
  output logic             eventFlag
);
  localparam int TOTAL       = PRE_LEN + FRAME_BITS;
  localparam int IDX_W       = $clog2(TOTAL);
  localparam int LAST_IDX    = TOTAL - 1;
  localparam int RELEASE_IDX = PRE_LEN + FRAME_BITS - DATA_BITS - 1;
  localparam int DATA_IDX    = RELEASE_IDX + 1;

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             mdcQ;
  logic             busyQ;
  logic             pending;

  logic divNz, tick, launch, riseEv, fallEv, lastBit, finish;

  always_comb begin
    divNz   = (divReg != '0);
    tick    = busyQ && divNz && (divCnt >= divReg - 1'b1);
    launch  = !busyQ && pending && divNz;
    riseEv  = tick && !mdcQ;
    fallEv  = tick && mdcQ;
    lastBit = (bitIdx == IDX_W'(LAST_IDX));
    finish  = fallEv && lastBit;

    strb.load     = launch;
    strb.shift    = fallEv && !lastBit && (bitIdx >= IDX_W'(PRE_LEN));
    strb.sample   = riseEv && isRead && (bitIdx >= IDX_W'(DATA_IDX));
    strb.capture  = finish && isRead && !pending && !frameWrEn;
    strb.preamble = (bitIdx < IDX_W'(PRE_LEN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg    <= '0;
      divCnt    <= '0;
      bitIdx    <= '0;
      mdcQ      <= 1'b0;
      busyQ     <= 1'b0;
      pending   <= 1'b0;
      donePulse <= 1'b0;
      eventFlag <= 1'b0;
    end else begin
      if (divWrEn) divReg <= divWrData;
      pending <= frameWrEn || (pending && !launch);
      if (busyQ && divNz) divCnt <= tick ? '0 : divCnt + 1'b1;
      else                divCnt <= '0;
      if (launch) begin
        busyQ  <= 1'b1;
        mdcQ   <= 1'b0;
        bitIdx <= '0;
      end else begin
        if (tick)             mdcQ   <= !mdcQ;
        if (finish)           busyQ  <= 1'b0;
        if (fallEv && !lastBit) bitIdx <= bitIdx + 1'b1;
      end
      donePulse <= finish;
      eventFlag <= finish || (eventFlag && !eventClr);
    end
  end

  assign divValue = divReg;
  assign busy     = busyQ;
  assign mdc      = mdcQ && divNz;
  assign mdioOe   = busyQ && !(isRead && (bitIdx >= IDX_W'(RELEASE_IDX)));

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!divNz && !busyQ) |=> !busyQ); // R1
  AST_MDC_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !tick) |=> $stable(mdcQ)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R7
  AST_EVENT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> eventFlag); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (eventClr && !finish) |=> !eventFlag); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> eventFlag); // R8
  AST_QUEUED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && frameWrEn) |=> pending); // R9
endmodule

// File: rtl/mdioMgmtLauncher.sv
module mdioMgmtLauncher
  import mdioMgmtPkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameWrEn,
  input  logic [31:0]      frameWrData,
  output logic [31:0]      frameRdData,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  output logic [DIV_W-1:0] divValue,
  input  logic             eventClr,
  input  logic             mdioIn,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             busy,
  output logic             donePulse,
  output logic             eventFlag
);
  pathStrb_t strb;
  logic      isRead;

  mdioMgmtCtrl #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) ctrl (
    .clk(clk), .rstN(rstN), .frameWrEn(frameWrEn), .divWrEn(divWrEn),
    .divWrData(divWrData), .eventClr(eventClr), .isRead(isRead),
    .strb(strb), .divValue(divValue), .mdc(mdc), .mdioOe(mdioOe),
    .busy(busy), .donePulse(donePulse), .eventFlag(eventFlag)
  );

  mdioMgmtPath path (
    .clk(clk), .frameWrEn(frameWrEn), .frameWrData(frameWrData),
    .strb(strb), .mdioIn(mdioIn), .frameRdData(frameRdData),
    .mdioOut(mdioOut), .isRead(isRead)
  );
endmodule

// File: tb/mdioMgmtLauncher_test.sv
module mdioMgmtLauncher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  localparam logic [31:0] V_WORD [NVEC] = '{32'h5092_A5C3, 32'h60AE_0000, 32'h5FFE_0001, 32'h6402_FFFF};
  localparam int          V_DIV  [NVEC] = '{1, 3, 2, 1};
  localparam logic [15:0] V_PHY  [NVEC] = '{16'h0000, 16'hB00F, 16'h0000, 16'h1234};

  logic clk = 1'b0, rstN = 1'b0;
  logic frameWrEn = 1'b0, divWrEn = 1'b0, eventClr = 1'b0, mdioIn = 1'b1;
  logic [31:0] frameWrData = '0, frameRdData;
  logic [7:0]  divWrData = '0, divValue;
  logic mdc, mdioOut, mdioOe, busy, donePulse, eventFlag;

  int checks = 0, errors = 0;
  logic [63:0] capBits, capOe;
  int highLen, doneCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdioMgmtLauncher uut (
    .clk(clk), .rstN(rstN), .frameWrEn(frameWrEn), .frameWrData(frameWrData),
    .frameRdData(frameRdData), .divWrEn(divWrEn), .divWrData(divWrData),
    .divValue(divValue), .eventClr(eventClr), .mdioIn(mdioIn), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .busy(busy), .donePulse(donePulse),
    .eventFlag(eventFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeFrame(input logic [31:0] w);
    @(negedge clk); frameWrData = w; frameWrEn = 1'b1;
    @(negedge clk); frameWrEn = 1'b0;
  endtask

  task automatic writeDiv(input int d);
    @(negedge clk); divWrData = 8'(d); divWrEn = 1'b1;
    @(negedge clk); divWrEn = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); eventClr = 1'b1;
    @(negedge clk); eventClr = 1'b0;
  endtask

  // Acts as the PHY: records MDIO at each MDC rise, drives read bits while MDC is low.
  task automatic captureFrame(input logic [15:0] phy, input bit injEn, input logic [31:0] injWord);
    int rises = 0, guard = 0;
    bit injected = 1'b0;
    logic prevMdc;
    prevMdc = mdc; highLen = 0; doneCount = 0; capBits = '0; capOe = '0;
    while (!(rises >= 64 && doneCount > 0) && guard < 5000) begin
      @(negedge clk); guard++;
      if (donePulse) doneCount++;
      if (mdc && !prevMdc && rises < 64) begin
        capBits[63-rises] = mdioOut; capOe[63-rises] = mdioOe; rises++;
      end
      if (mdc && rises == 1) highLen++;
      if (!mdc) mdioIn = (rises >= 48 && rises < 64) ? phy[63-rises] : 1'b1;
      prevMdc = mdc;
      if (injEn && rises == 10 && !injected) begin
        frameWrData = injWord; frameWrEn = 1'b1;
        @(negedge clk); frameWrEn = 1'b0; injected = 1'b1;
        if (donePulse) doneCount++;
        prevMdc = mdc;
      end
    end
    @(negedge clk);
    if (donePulse) doneCount++;
    mdioIn = 1'b1;
  endtask

  function automatic logic [63:0] oeExpect(input logic [31:0] w);
    logic [63:0] m = '1;
    if (w[29:28] == 2'b10) for (int n = 47; n < 64; n++) m[63-n] = 1'b0;
    return m;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] expBits, expOe;
    logic [31:0] expRd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!mdc && !mdioOe && !donePulse && !eventFlag && !busy && divValue == 0,
          "R10", "reset outputs", {mdc, mdioOe, donePulse, eventFlag, busy, divValue}, 64'h0);

    // Vector table walk: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      writeDiv(V_DIV[i]);
      writeFrame(V_WORD[i]);
      captureFrame(V_PHY[i], 1'b0, 32'h0);
      expBits = {32'hFFFF_FFFF, V_WORD[i]};
      expOe   = oeExpect(V_WORD[i]);
      expRd   = (V_WORD[i][29:28] == 2'b10) ? {V_WORD[i][31:16], V_PHY[i]} : V_WORD[i];
      check(capOe == expOe, (V_WORD[i][29:28] == 2'b10) ? "R4" : "R5", "output enable pattern", capOe, expOe);
      check((capBits & expOe) == (expBits & expOe), "R2", "serial bits", capBits & expOe, expBits & expOe);
      check(highLen == V_DIV[i], "R3", "MDC high phase clocks", 64'(highLen), 64'(V_DIV[i]));
      check(frameRdData == expRd, (V_WORD[i][29:28] == 2'b10) ? "R4" : "R5", "frame word readback", 64'(frameRdData), 64'(expRd));
      check(doneCount == 1, "R7", "done pulse count", 64'(doneCount), 64'd1);
      check(eventFlag == 1'b1, "R7", "event flag set", 64'(eventFlag), 64'd1);
      pulseClear();
      check(eventFlag == 1'b0, "R8", "event flag cleared", 64'(eventFlag), 64'd0);
    end

    // R1 and R6: frame word written with divider zero is held
    writeDiv(0);
    writeFrame(32'h5ACF_3C3C);
    begin
      bit activity = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (mdc || mdioOe || busy) activity = 1'b1;
      end
      check(!activity, "R1", "no activity while divider zero", 64'(activity), 64'd0);
    end
    writeDiv(2);
    captureFrame(16'h0, 1'b0, 32'h0);
    expBits = {32'hFFFF_FFFF, 32'h5ACF_3C3C};
    check(capBits == expBits, "R6", "held word sent after divider write", capBits, expBits);
    check(capOe == '1, "R6", "held frame driven", capOe, '1);
    pulseClear();

    // R9: write during a read frame is queued and not overwritten by read data
    writeDiv(3);
    writeFrame(32'h6086_0000);
    captureFrame(16'hC0DE, 1'b1, 32'h5133_7E01);
    check(frameRdData == 32'h5133_7E01, "R9", "newer word kept over read data", 64'(frameRdData), 64'h5133_7E01);
    captureFrame(16'h0, 1'b0, 32'h0);
    expBits = {32'hFFFF_FFFF, 32'h5133_7E01};
    check(capBits == expBits, "R9", "queued word sent next", capBits, expBits);
    check(doneCount == 1, "R9", "queued frame completes", 64'(doneCount), 64'd1);
    pulseClear();

    // R8: clear on the exact edge a frame ends; set must win
    writeDiv(1);
    writeFrame(32'h5000_0000);
    repeat (128) @(negedge clk);
    eventClr = 1'b1;
    @(negedge clk);
    eventClr = 1'b0;
    check(donePulse == 1'b1, "R8", "frame ends on clear edge", 64'(donePulse), 64'd1);
    check(eventFlag == 1'b1, "R8", "set wins over clear", 64'(eventFlag), 64'd1);
    pulseClear();
    check(eventFlag == 1'b0, "R8", "later clear drops flag", 64'(eventFlag), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule